// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter with Terminal-Count Outputs

This block is a small synchronous binary counter whose direction is picked by one level-sensitive input. Low means count up and high means count down. Counting happens on the rising clock edge only while an active-low enable is asserted. An active-low preset works without the clock: while it is held low, the count output shows the data bus at once and ignores counting. When the preset is released, the counter keeps the value that was on the bus at that moment.

Two flags support chaining and divider use. The terminal flag is high while the count sits at the end of its range for the current direction: all ones when counting up, zero when counting down. The ripple output is active-low. It repeats the terminal flag, but only during the low half of the clock period.

A divide-by-N circuit is built by presetting a start value and reloading it each time the terminal flag comes up. The width and the structure of the incrementer are parameters.

Top module: `udc_counter`

## Requirements
- R1: The count changes only on a rising clock edge, with all bits updating together. A falling edge never changes it.
- R2: With enable_n high (1) at a rising edge, the count keeps its value.
- R3: With enable_n low and down_up low (0 = up), each rising edge adds one, and 15 wraps to 0.
- R4: With enable_n low and down_up high (1 = down), each rising edge subtracts one, and 0 wraps to 15.
- R5: While load_n is low, count equals data without waiting for a clock edge, follows any change of data, and is not changed by rising edges.
- R6: When load_n returns high, count holds the value data had at that moment. The next enabled rising edge counts on from that value.
- R7: Changing enable_n or down_up between rising edges leaves the count unchanged until the next rising edge.
- R8: max_min is 1 exactly when (down_up = 1 and count = 0) or (down_up = 0 and count = 15). It follows a change of down_up at once, with no clock edge.
- R9: rco_n is 0 exactly when max_min is 1 and clk is 0. Otherwise it is 1.
- R10: Counting down from a preset of 4, with the preset reapplied across the rising edge that follows each terminal flag, gives a count sequence that repeats every 5 clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| enable_n | input | 1 | Active-low count enable |
| down_up | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Active-low preset, independent of the clock |
| data | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| max_min | output | 1 | Terminal count for the current direction |
| rco_n | output | 1 | Active-low terminal pulse, gated by the low clock phase |

## Verification
On every rising edge outside a preset, the assertions check the hold, increment and decrement behaviour, including wraparound. They also check that rco_n equals the inverse of max_min in the low clock phase and stays high in the high phase. The following can only be shown by the bench's scenarios, because they involve the clock-free preset path or a sequence over many edges:
- the count following the data bus while the preset is held;
- the value kept after release;
- control changes between edges having no effect;
- the terminal flag reacting at once to a direction flip;
- the five-edge period of the reloading divider.

// File: rtl/udc_pkg.sv
package udc_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;
endpackage

// File: rtl/udc_next.sv
module udc_next
   import udc_pkg::*;
#(
   parameter int WIDTH        = 4,
   parameter bit TOGGLE_CHAIN = 1'b1
) (
   input  logic [WIDTH-1:0] base_i,
   input  dir_e             dir_i,
   output logic [WIDTH-1:0] next_o
);
   generate
      if (TOGGLE_CHAIN) begin : g_toggle
         // bit i flips when every lower bit sits at the carry/borrow level
         logic [WIDTH-1:0] flip;
         logic             dn;
         assign dn      = (dir_i == DIR_DOWN);
         assign flip[0] = 1'b1;
         for (genvar i = 1; i < WIDTH; i++) begin : g_chain
            assign flip[i] = flip[i-1] & (base_i[i-1] ^ dn);
         end
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign next_o[i] = base_i[i] ^ flip[i];
         end
      end else begin : g_adder
         always_comb begin
            if (dir_i == DIR_DOWN) next_o = base_i - WIDTH'(1);
            else                   next_o = base_i + WIDTH'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/udc_state.sv
module udc_state
   import udc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             load_n_i,
   input  logic             enable_n_i,
   input  dir_e             dir_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic [WIDTH-1:0] next_i,
   output logic [WIDTH-1:0] base_o,
   output logic [WIDTH-1:0] count_o
);
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] pre_q;
   logic             pend_q;

   // transparent capture of the preset bus while load is held
   always_latch begin
      if (!load_n_i) pre_q <= data_i;
   end

   always_ff @(posedge clk_i or negedge load_n_i) begin
      if (!load_n_i) begin
         cnt_q  <= data_i;
         pend_q <= 1'b1;
      end else begin
         pend_q <= 1'b0;
         if (!enable_n_i) cnt_q <= next_i;
         else             cnt_q <= base_o;
      end
   end

   assign base_o  = pend_q ? pre_q : cnt_q;
   assign count_o = load_n_i ? base_o : data_i;

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!load_n_i)
      enable_n_i |=> (count_o == $past(count_o)));                          // R2
   AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!load_n_i)
      (!enable_n_i && dir_i == DIR_UP)
         |=> (count_o == WIDTH'($past(count_o) + WIDTH'(1))));              // R3
   AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!load_n_i)
      (!enable_n_i && dir_i == DIR_DOWN)
         |=> (count_o == WIDTH'($past(count_o) - WIDTH'(1))));              // R4
endmodule

// File: rtl/udc_term.sv
module udc_term
   import udc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] count_i,
   input  dir_e             dir_i,
   output logic             flag_o
);
   localparam logic [WIDTH-1:0] TOP_VAL = '1;
   localparam logic [WIDTH-1:0] BOT_VAL = '0;

   always_comb begin
      if (dir_i == DIR_DOWN) flag_o = (count_i == BOT_VAL);
      else                   flag_o = (count_i == TOP_VAL);
   end
endmodule

// File: rtl/udc_ripple.sv
module udc_ripple (
   input  logic clk_i,
   input  logic flag_i,
   output logic rco_n_o
);
   assign rco_n_o = ~(flag_i & ~clk_i);
endmodule

// File: rtl/udc_counter.sv
module udc_counter
   import udc_pkg::*;
#(
   parameter int WIDTH        = 4,
   parameter bit TOGGLE_CHAIN = 1'b1
) (
   input  logic             clk,
   input  logic             enable_n,
   input  logic             down_up,
   input  logic             load_n,
   input  logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] count,
   output logic             max_min,
   output logic             rco_n
);
   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("udc_counter: WIDTH must lie in 2..32");
      end
   endgenerate

   dir_e             dir;
   logic [WIDTH-1:0] base;
   logic [WIDTH-1:0] nxt;

   assign dir = down_up ? DIR_DOWN : DIR_UP;

   udc_next #(.WIDTH(WIDTH), .TOGGLE_CHAIN(TOGGLE_CHAIN)) u_next (
      .base_i (base),
      .dir_i  (dir),
      .next_o (nxt)
   );

   udc_state #(.WIDTH(WIDTH)) u_state (
      .clk_i      (clk),
      .load_n_i   (load_n),
      .enable_n_i (enable_n),
      .dir_i      (dir),
      .data_i     (data),
      .next_i     (nxt),
      .base_o     (base),
      .count_o    (count)
   );

   udc_term #(.WIDTH(WIDTH)) u_term (
      .count_i (count),
      .dir_i   (dir),
      .flag_o  (max_min)
   );

   udc_ripple u_ripple (
      .clk_i   (clk),
      .flag_i  (max_min),
      .rco_n_o (rco_n)
   );

   // sampled just before the rising edge: clock low, ripple mirrors the flag
   AST_RCO_LOW_PHASE: assert property (@(posedge clk) disable iff (!load_n)
      (rco_n == !max_min));                                                 // R9
   // sampled just before the falling edge: clock high, ripple idle
   AST_RCO_HIGH_PHASE: assert property (@(negedge clk) disable iff (!load_n)
      rco_n);                                                               // R9
endmodule

// File: tb/sim_udc_counter.sv
module sim_udc_counter;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       enable_n = 1'b1;
   logic       down_up = 1'b0;
   logic       load_n = 1'b0;
   logic [3:0] data = 4'd0;
   logic [3:0] count;
   logic       max_min;
   logic       rco_n;

   int n_chk = 0;
   int n_bad = 0;
   int exp_cnt = 0;

   udc_counter u0 (
      .clk      (clk),
      .enable_n (enable_n),
      .down_up  (down_up),
      .load_n   (load_n),
      .data     (data),
      .count    (count),
      .max_min  (max_min),
      .rco_n    (rco_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int mm_of(input int c, input logic d);
      if (d) return (c == 0) ? 1 : 0;
      return (c == 15) ? 1 : 0;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic low_phase();
      @(negedge clk);
      #1;
   endtask

   // preset v: hold load across one rising edge, release in the low phase
   task automatic do_load(input int v);
      data = 4'(v);
      load_n = 1'b0;
      #1;
      chk("R5", "count follows data at once", int'(count), v);
      tick();
      chk("R5", "load overrides edge", int'(count), v);
      low_phase();
      load_n = 1'b1;
      #1;
      chk("R6", "value kept after release", int'(count), v);
      exp_cnt = v;
   endtask

   task automatic t_reset();
      #1;
      chk("R5", "initial preset count", int'(count), 0);
      chk("R8", "initial max_min", int'(max_min), 0);
      chk("R9", "initial rco_n", int'(rco_n), 1);
   endtask

   task automatic t_up_wrap();
      enable_n = 1'b0;
      down_up = 1'b0;
      do_load(13);
      for (int k = 0; k < 5; k++) begin
         tick();
         exp_cnt = (exp_cnt + 1) % 16;
         chk("R3", "up count", int'(count), exp_cnt);
         chk("R8", "max_min up", int'(max_min), mm_of(exp_cnt, 1'b0));
         chk("R9", "rco_n high phase", int'(rco_n), 1);
         low_phase();
         chk("R1", "no change on falling edge", int'(count), exp_cnt);
         chk("R9", "rco_n low phase", int'(rco_n), 1 - mm_of(exp_cnt, 1'b0));
      end
   endtask

   task automatic t_down_wrap();
      enable_n = 1'b0;
      down_up = 1'b1;
      do_load(2);
      for (int k = 0; k < 5; k++) begin
         tick();
         exp_cnt = (exp_cnt + 15) % 16;
         chk("R4", "down count", int'(count), exp_cnt);
         chk("R8", "max_min down", int'(max_min), mm_of(exp_cnt, 1'b1));
         low_phase();
         chk("R9", "rco_n low phase", int'(rco_n), 1 - mm_of(exp_cnt, 1'b1));
      end
   endtask

   task automatic t_hold();
      enable_n = 1'b1;
      down_up = 1'b0;
      do_load(7);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R2", "hold while disabled", int'(count), 7);
         down_up = ~down_up;
         #1;
         chk("R7", "direction flip between edges", int'(count), 7);
      end
      low_phase();
      enable_n = 1'b0;
      #1;
      chk("R7", "enable change between edges", int'(count), 7);
      enable_n = 1'b1;
      tick();
      chk("R2", "enable pulse missed the edge", int'(count), 7);
      low_phase();
      down_up = 1'b0;
      enable_n = 1'b0;
      #1;
      chk("R7", "enable set before edge", int'(count), 7);
      tick();
      chk("R1", "counts at the rising edge", int'(count), 8);
   endtask

   task automatic t_load_phases();
      enable_n = 1'b0;
      down_up = 1'b1;
      tick();
      // preset asserted in the high phase
      data = 4'd9;
      load_n = 1'b0;
      #1;
      chk("R5", "load in high phase", int'(count), 9);
      data = 4'd6;
      #1;
      chk("R5", "follows data change", int'(count), 6);
      tick();
      chk("R5", "edge ignored under load", int'(count), 6);
      low_phase();
      data = 4'd11;
      #1;
      chk("R5", "follows data in low phase", int'(count), 11);
      load_n = 1'b1;
      #1;
      chk("R6", "release keeps last data", int'(count), 11);
      data = 4'd2;
      #1;
      chk("R6", "data ignored after release", int'(count), 11);
      tick();
      chk("R6", "counts on from kept value", int'(count), 10);
      // preset asserted in the low phase, released in the high phase
      low_phase();
      data = 4'd3;
      load_n = 1'b0;
      #1;
      chk("R5", "load in low phase", int'(count), 3);
      tick();
      load_n = 1'b1;
      #1;
      chk("R6", "release in high phase", int'(count), 3);
      tick();
      chk("R6", "count after high-phase release", int'(count), 2);
   endtask

   task automatic t_dir_flip();
      enable_n = 1'b1;
      down_up = 1'b0;
      do_load(15);
      chk("R8", "max at 15 up", int'(max_min), 1);
      chk("R9", "rco_n low phase at 15 up", int'(rco_n), 0);
      down_up = 1'b1;
      #1;
      chk("R8", "flag drops on flip", int'(max_min), 0);
      chk("R9", "rco_n releases on flip", int'(rco_n), 1);
      do_load(0);
      chk("R8", "min at 0 down", int'(max_min), 1);
      down_up = 1'b0;
      #1;
      chk("R8", "flag drops at 0 up", int'(max_min), 0);
      down_up = 1'b1;
      tick();
      chk("R9", "rco_n high phase with flag", int'(rco_n), 1);
      chk("R8", "flag still set", int'(max_min), 1);
   endtask

   task automatic t_modn();
      int pulses = 0;
      logic reload = 1'b0;
      enable_n = 1'b0;
      down_up = 1'b1;
      do_load(4);
      for (int k = 0; k < 25; k++) begin
         tick();
         if (reload) exp_cnt = 4;
         else        exp_cnt = (exp_cnt + 15) % 16;
         chk("R10", "divider count", int'(count), exp_cnt);
         if (max_min) pulses++;
         reload = max_min;
         low_phase();
         load_n = ~reload;
      end
      load_n = 1'b1;
      chk("R10", "terminal pulses in 25 edges", pulses, 5);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_up_wrap();
            t_down_wrap();
            t_hold();
            t_load_phases();
            t_dir_flip();
            t_modn();
         end
         begin
            #(CLK_PERIOD * 20000);
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule